// File: doc/BRIEF.md
# Trace Comparator Register Access Permission Checker

This block sits beside the system-register decode path and judges each access aimed at the group of sixteen address-comparator value registers. For every request it checks the five encoding fields against the group's fixed pattern. It rebuilds the register index from the encoding. It then walks a priority chain of trap controls that depends on the privilege level the access comes from. The verdict is one of four outcomes: the encoding is not in the group, the access is undefined, the access traps to a higher level, or the access is permitted.

Requests arrive as a one-cycle strobe together with the encoding, a direction flag, the current privilege level (0 to 3), one trap-enable bit per level 1..3, flags saying whether level 2 is enabled and level 3 exists, and flags saying whether level 2 or level 3 runs in the narrow (32-bit) execution mode. The verdict appears on registered outputs one clock later. A trap carries a fixed syndrome class, and a permitted access carries the decoded index. The block does not enter the exception and holds no register contents.

Top module: `sysreg_acc_checker`

## Requirements
- R1: A response (`rsp_valid`=1) appears exactly one cycle after each cycle with `req_valid`=1; in every other cycle `rsp_valid` is 0 and every other output is 0, including after reset.
- R2: The encoding belongs to the group only when op0=2'b10, op1=3'b001, CRn=4'b0010, CRm[0]=0 and op2[2:1]=2'b00; otherwise the response shows only `rsp_nomatch`=1, with no trap, no undefined result, target 0, syndrome 0 and index 0, whatever the level and trap bits.
- R3: For a matching encoding, `rsp_index` = {op2[0], CRm[3:1]}, covering 0 to 15.
- R4: A matching access from level 0 gives `rsp_undef`=1, whatever the trap bits.
- R5: From level 1 the checks run in this order: the level-1 trap bit traps to level 1; otherwise level 2 enabled, not narrow and its trap bit set traps to level 2; otherwise level 3 present, not narrow and its trap bit set traps to level 3; otherwise the access is allowed.
- R6: From level 2: the level-2 trap bit traps to level 2 without regard to the level-2 enabled or narrow flags; otherwise the level-3 condition of R5 traps to level 3; otherwise the access is allowed.
- R7: From level 3: the level-3 trap bit traps to level 3 without regard to the present or narrow flags; otherwise the access is allowed.
- R8: A trap response has `rsp_target` equal to the destination level (2'd1, 2'd2 or 2'd3) and `rsp_syndrome`=6'h18; every non-trap response has target 0 and syndrome 0.
- R9: Reads and writes receive identical verdicts; `rsp_write` repeats the request's direction flag (1 = write).
- R10: Every response asserts exactly one of `rsp_nomatch`, `rsp_undef`, `rsp_trap`, `rsp_allow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| cur_lvl | input | 2 | Privilege level of the access |
| trap_en_l1 | input | 1 | Level-1 trap control |
| trap_en_l2 | input | 1 | Level-2 trap control |
| trap_en_l3 | input | 1 | Level-3 trap control |
| l2_enabled | input | 1 | Level 2 is enabled |
| l3_present | input | 1 | Level 3 is implemented |
| l2_narrow | input | 1 | Level 2 runs in narrow mode |
| l3_narrow | input | 1 | Level 3 runs in narrow mode |
| rsp_valid | output | 1 | Verdict valid |
| rsp_nomatch | output | 1 | Encoding outside the group |
| rsp_undef | output | 1 | Undefined-instruction result |
| rsp_trap | output | 1 | Trap to a higher level |
| rsp_allow | output | 1 | Access permitted |
| rsp_target | output | 2 | Trap destination level, 0 when no trap |
| rsp_syndrome | output | 6 | Syndrome class of a trap, 0 otherwise |
| rsp_index | output | 4 | Decoded register index |
| rsp_write | output | 1 | Direction of the judged access |

## Verification
The assertions check on every cycle that the response follows each strobe by exactly one cycle, that each verdict is one-hot, that every trap carries the fixed class and never targets a level below the requesting one, that a level-0 request is never allowed or trapped, that a level-3 request with its trap bit set is never allowed, and that a no-match verdict is quiet. The exact destination chosen when several trap conditions hold at once, the index rebuilt from each of the sixteen encodings, and the rejection of each individually wrong field can only be shown by the bench's scenarios. Those scenarios sweep every level against all 128 combinations of control flags, feed back-to-back and gapped requests, and mutate each encoding field.

// File: rtl/sysreg_acc_pkg.sv
package sysreg_acc_pkg;
   typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;
   typedef enum logic [1:0] {
      OUT_NOMATCH = 2'd0,
      OUT_UNDEF   = 2'd1,
      OUT_TRAP    = 2'd2,
      OUT_ALLOW   = 2'd3
   } outcome_e;
   typedef struct packed {
      outcome_e kind;
      lvl_e     target;
   } verdict_t;
endpackage

// File: rtl/sysreg_acc_decode.sv
module sysreg_acc_decode #(
   parameter logic [1:0] OP0_VAL    = 2'b10,
   parameter logic [2:0] OP1_VAL    = 3'b001,
   parameter logic [3:0] CRN_VAL    = 4'b0010,
   parameter bit         GATE_INDEX = 1'b1,
   parameter int         IDX_W      = 4
) (
   input  logic [1:0]       op0,
   input  logic [2:0]       op1,
   input  logic [3:0]       crn,
   input  logic [3:0]       crm,
   input  logic [2:0]       op2,
   output logic             hit,
   output logic [IDX_W-1:0] index
);
   localparam int CRM_IDX_W = IDX_W - 1;

   if (IDX_W != 4) begin : g_bad_idx
      $error("sysreg_acc_decode: IDX_W must be 4 for this encoding");
   end

   logic [IDX_W-1:0] raw_index;

   always_comb begin
      hit = (op0 == OP0_VAL) && (op1 == OP1_VAL) && (crn == CRN_VAL)
            && (crm[0] == 1'b0) && (op2[2:1] == 2'b00);
      raw_index = {op2[0], crm[CRM_IDX_W:1]};
   end

   if (GATE_INDEX) begin : g_gated
      assign index = hit ? raw_index : '0;
   end else begin : g_raw
      assign index = raw_index;
   end
endmodule

// File: rtl/sysreg_acc_policy.sv
module sysreg_acc_policy
   import sysreg_acc_pkg::*;
(
   input  lvl_e     lvl,
   input  logic     trap_l1,
   input  logic     trap_l2,
   input  logic     trap_l3,
   input  logic     l2_on,
   input  logic     l3_on,
   input  logic     l2_nar,
   input  logic     l3_nar,
   output verdict_t verdict
);
   logic l2_gate;
   logic l3_gate;

   always_comb begin
      l2_gate = l2_on && !l2_nar && trap_l2;
      l3_gate = l3_on && !l3_nar && trap_l3;
      verdict = '{kind: OUT_ALLOW, target: LVL0};
      unique case (lvl)
         LVL0: verdict = '{kind: OUT_UNDEF, target: LVL0};
         LVL1: begin
            if (trap_l1)      verdict = '{kind: OUT_TRAP, target: LVL1};
            else if (l2_gate) verdict = '{kind: OUT_TRAP, target: LVL2};
            else if (l3_gate) verdict = '{kind: OUT_TRAP, target: LVL3};
         end
         LVL2: begin
            if (trap_l2)      verdict = '{kind: OUT_TRAP, target: LVL2};
            else if (l3_gate) verdict = '{kind: OUT_TRAP, target: LVL3};
         end
         LVL3: begin
            if (trap_l3)      verdict = '{kind: OUT_TRAP, target: LVL3};
         end
         default:            verdict = '{kind: OUT_UNDEF, target: LVL0};
      endcase
   end
endmodule

// File: rtl/sysreg_acc_checker.sv
module sysreg_acc_checker
   import sysreg_acc_pkg::*;
#(
   parameter int         SYN_W      = 6,
   parameter logic [5:0] TRAP_CLASS = 6'h18,
   parameter int         IDX_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_op0,
   input  logic [2:0]       req_op1,
   input  logic [3:0]       req_crn,
   input  logic [3:0]       req_crm,
   input  logic [2:0]       req_op2,
   input  logic             req_write,
   input  logic [1:0]       cur_lvl,
   input  logic             trap_en_l1,
   input  logic             trap_en_l2,
   input  logic             trap_en_l3,
   input  logic             l2_enabled,
   input  logic             l3_present,
   input  logic             l2_narrow,
   input  logic             l3_narrow,
   output logic             rsp_valid,
   output logic             rsp_nomatch,
   output logic             rsp_undef,
   output logic             rsp_trap,
   output logic             rsp_allow,
   output logic [1:0]       rsp_target,
   output logic [SYN_W-1:0] rsp_syndrome,
   output logic [IDX_W-1:0] rsp_index,
   output logic             rsp_write
);
   if (SYN_W < 1 || SYN_W > 6) begin : g_bad_syn
      $error("sysreg_acc_checker: SYN_W must be 1..6");
   end
   if (SYN_W < 6 && (TRAP_CLASS >> SYN_W) != 0) begin : g_bad_class
      $error("sysreg_acc_checker: TRAP_CLASS does not fit SYN_W");
   end

   logic             hit;
   logic [IDX_W-1:0] idx_d;
   verdict_t         verdict;
   outcome_e         kind_d;

   sysreg_acc_decode #(.IDX_W(IDX_W)) u_decode (
      .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
      .hit(hit), .index(idx_d)
   );

   sysreg_acc_policy u_policy (
      .lvl(lvl_e'(cur_lvl)), .trap_l1(trap_en_l1), .trap_l2(trap_en_l2),
      .trap_l3(trap_en_l3), .l2_on(l2_enabled), .l3_on(l3_present),
      .l2_nar(l2_narrow), .l3_nar(l3_narrow), .verdict(verdict)
   );

   assign kind_d = hit ? verdict.kind : OUT_NOMATCH;

   always_ff @(posedge clk) begin
      if (!rst_n || !req_valid) begin
         rsp_valid    <= 1'b0;
         rsp_nomatch  <= 1'b0;
         rsp_undef    <= 1'b0;
         rsp_trap     <= 1'b0;
         rsp_allow    <= 1'b0;
         rsp_target   <= '0;
         rsp_syndrome <= '0;
         rsp_index    <= '0;
         rsp_write    <= 1'b0;
      end else begin
         rsp_valid    <= 1'b1;
         rsp_nomatch  <= (kind_d == OUT_NOMATCH);
         rsp_undef    <= (kind_d == OUT_UNDEF);
         rsp_trap     <= (kind_d == OUT_TRAP);
         rsp_allow    <= (kind_d == OUT_ALLOW);
         rsp_target   <= (kind_d == OUT_TRAP) ? verdict.target : 2'd0;
         rsp_syndrome <= (kind_d == OUT_TRAP) ? TRAP_CLASS[SYN_W-1:0] : '0;
         rsp_index    <= idx_d;
         rsp_write    <= req_write;
      end
   end
endmodule

// File: rtl/sysreg_acc_sva.sv
module sysreg_acc_sva #(
   parameter int         SYN_W      = 6,
   parameter logic [5:0] TRAP_CLASS = 6'h18,
   parameter int         IDX_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       cur_lvl,
   input logic             trap_en_l3,
   input logic             rsp_valid,
   input logic             rsp_nomatch,
   input logic             rsp_undef,
   input logic             rsp_trap,
   input logic             rsp_allow,
   input logic [1:0]       rsp_target,
   input logic [SYN_W-1:0] rsp_syndrome,
   input logic [IDX_W-1:0] rsp_index
);
   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_nomatch, rsp_undef, rsp_trap, rsp_allow}) == 1); // R10
   AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_nomatch |-> (rsp_target == 2'd0 && rsp_syndrome == '0 && rsp_index == '0)); // R2
   AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_lvl == 2'd0) |=> (rsp_undef || rsp_nomatch)); // R4
   AST_LVL3_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_lvl == 2'd3 && trap_en_l3) |=> !rsp_allow); // R7
   AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_syndrome == TRAP_CLASS[SYN_W-1:0] && rsp_target != 2'd0)); // R8
   AST_TRAP_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_lvl != 2'd0) |=> (!rsp_trap || rsp_target >= $past(cur_lvl))); // R5
endmodule

bind sysreg_acc_checker sysreg_acc_sva #(
   .SYN_W(SYN_W), .TRAP_CLASS(TRAP_CLASS), .IDX_W(IDX_W)
) sva_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lvl(cur_lvl),
   .trap_en_l3(trap_en_l3), .rsp_valid(rsp_valid), .rsp_nomatch(rsp_nomatch),
   .rsp_undef(rsp_undef), .rsp_trap(rsp_trap), .rsp_allow(rsp_allow),
   .rsp_target(rsp_target), .rsp_syndrome(rsp_syndrome), .rsp_index(rsp_index)
);

// File: tb/sysreg_acc_checker_tb_top.sv
module sysreg_acc_checker_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_op0 = '0;
   logic [2:0] req_op1 = '0;
   logic [3:0] req_crn = '0;
   logic [3:0] req_crm = '0;
   logic [2:0] req_op2 = '0;
   logic req_write = 1'b0;
   logic [1:0] cur_lvl = '0;
   logic trap_en_l1 = 0, trap_en_l2 = 0, trap_en_l3 = 0;
   logic l2_enabled = 0, l3_present = 0, l2_narrow = 0, l3_narrow = 0;
   logic rsp_valid, rsp_nomatch, rsp_undef, rsp_trap, rsp_allow, rsp_write;
   logic [1:0] rsp_target;
   logic [5:0] rsp_syndrome;
   logic [3:0] rsp_index;

   always #5 clk = ~clk;

   sysreg_acc_checker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op0(req_op0),
      .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
      .req_write(req_write), .cur_lvl(cur_lvl), .trap_en_l1(trap_en_l1),
      .trap_en_l2(trap_en_l2), .trap_en_l3(trap_en_l3), .l2_enabled(l2_enabled),
      .l3_present(l3_present), .l2_narrow(l2_narrow), .l3_narrow(l3_narrow),
      .rsp_valid(rsp_valid), .rsp_nomatch(rsp_nomatch), .rsp_undef(rsp_undef),
      .rsp_trap(rsp_trap), .rsp_allow(rsp_allow), .rsp_target(rsp_target),
      .rsp_syndrome(rsp_syndrome), .rsp_index(rsp_index), .rsp_write(rsp_write)
   );

   typedef struct {
      bit       valid;
      bit [3:0] kind;     // {nomatch, undef, trap, allow}
      bit [1:0] target;
      bit [5:0] syn;
      bit [3:0] idx;
      bit       wr;
      string    tag;
   } exp_t;

   exp_t scb_q[$];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // expected verdict from the requirements
   task automatic issue(input bit [1:0] op0, input bit [2:0] op1, input bit [3:0] crn,
                        input bit [3:0] crm, input bit [2:0] op2, input bit wr,
                        input bit [1:0] lvl, input bit [6:0] f);
      exp_t e;
      bit t1, t2, t3, e2, p3, n2, n3, grp, g3;
      {t1, t2, t3, e2, p3, n2, n3} = f;
      grp = (op0 == 2'b10) && (op1 == 3'b001) && (crn == 4'b0010) && !crm[0] && (op2[2:1] == 2'b00);
      g3 = p3 && !n3 && t3;
      e.valid = 1'b1; e.wr = wr; e.target = 2'd0; e.syn = 6'h0; e.idx = 4'h0;
      if (!grp) begin
         e.kind = 4'b1000; e.tag = "R2";
      end else begin
         e.idx = {op2[0], crm[3:1]};
         e.kind = 4'b0001;
         case (lvl)
            2'd0: begin e.kind = 4'b0100; e.tag = "R4"; end
            2'd1: begin
               e.tag = "R5";
               if (t1) e.target = 2'd1;
               else if (e2 && !n2 && t2) e.target = 2'd2;
               else if (g3) e.target = 2'd3;
            end
            2'd2: begin
               e.tag = "R6";
               if (t2) e.target = 2'd2;
               else if (g3) e.target = 2'd3;
            end
            default: begin
               e.tag = "R7";
               if (t3) e.target = 2'd3;
            end
         endcase
         if (e.target != 2'd0) begin e.kind = 4'b0010; e.syn = 6'h18; end
      end
      @(negedge clk);
      req_valid = 1'b1; req_op0 = op0; req_op1 = op1; req_crn = crn; req_crm = crm;
      req_op2 = op2; req_write = wr; cur_lvl = lvl;
      {trap_en_l1, trap_en_l2, trap_en_l3, l2_enabled, l3_present, l2_narrow, l3_narrow} = f;
      scb_q.push_back(e);
   endtask

   task automatic idle();
      exp_t e;
      e.valid = 1'b0; e.kind = 4'b0000; e.target = 2'd0; e.syn = 6'h0; e.idx = 4'h0;
      e.wr = 1'b0; e.tag = "R1";
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b1; // direction toggles while idle and must not leak out
      scb_q.push_back(e);
   endtask

   // monitor: samples 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (scb_q.size() > 0) begin
            exp_t e;
            e = scb_q.pop_front();
            check(rsp_valid == e.valid, "R1", "rsp_valid", rsp_valid, e.valid);
            if (!e.valid) begin
               check({rsp_nomatch, rsp_undef, rsp_trap, rsp_allow, rsp_target, rsp_syndrome,
                      rsp_index, rsp_write} == '0, "R1", "idle outputs",
                     {rsp_nomatch, rsp_undef, rsp_trap, rsp_allow, rsp_write}, 0);
            end else begin
               check({rsp_nomatch, rsp_undef, rsp_trap, rsp_allow} == e.kind, e.tag,
                     "outcome {nomatch,undef,trap,allow}",
                     {rsp_nomatch, rsp_undef, rsp_trap, rsp_allow}, e.kind);
               check(rsp_target == e.target, e.tag, "target", rsp_target, e.target);
               check(rsp_syndrome == e.syn, "R8", "syndrome", rsp_syndrome, e.syn);
               check(rsp_index == e.idx, "R3", "index", rsp_index, e.idx);
               check(rsp_write == e.wr, "R9", "write flag", rsp_write, e.wr);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R1", "watchdog expired", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check({rsp_valid, rsp_nomatch, rsp_undef, rsp_trap, rsp_allow, rsp_target,
             rsp_syndrome, rsp_index, rsp_write} == '0, "R1", "outputs in reset",
            rsp_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 / R9: every index, read then write, at level 3 with no traps
      for (int i = 0; i < 16; i++) begin
         issue(2'b10, 3'b001, 4'b0010, {i[2:0], 1'b0}, {2'b00, i[3]}, 1'b0, 2'd3, 7'h0);
         issue(2'b10, 3'b001, 4'b0010, {i[2:0], 1'b0}, {2'b00, i[3]}, 1'b1, 2'd3, 7'h0);
      end
      idle();

      // R2: one wrong field at a time, with every trap bit set
      issue(2'b11, 3'b001, 4'b0010, 4'h6, 3'b001, 1'b0, 2'd1, 7'h7F);
      issue(2'b10, 3'b000, 4'b0010, 4'h6, 3'b001, 1'b0, 2'd1, 7'h7F);
      issue(2'b10, 3'b001, 4'b0011, 4'h6, 3'b001, 1'b1, 2'd2, 7'h7F);
      issue(2'b10, 3'b001, 4'b0010, 4'h7, 3'b001, 1'b0, 2'd3, 7'h7F);
      issue(2'b10, 3'b001, 4'b0010, 4'h6, 3'b011, 1'b1, 2'd0, 7'h7F);
      issue(2'b10, 3'b001, 4'b0010, 4'h6, 3'b101, 1'b0, 2'd1, 7'h7F);
      idle();
      idle();

      // R4..R8: every level against every flag combination, mixed gaps
      for (int lv = 0; lv < 4; lv++) begin
         for (int f = 0; f < 128; f++) begin
            issue(2'b10, 3'b001, 4'b0010, {f[2:0], 1'b0}, {2'b00, f[3]}, f[0],
                  lv[1:0], f[6:0]);
            if (f % 9 == 4) idle();
         end
      end
      idle();
      idle();
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule